// File: doc/BRIEF.md
# Multiply-Divide Engine with HI/LO Result Registers

This block is a background integer multiply and divide engine that owns two result registers, HI and LO. A requester presents a 6-bit function code, two 32-bit operands and a valid strobe. Arithmetic requests run one bit per clock. A multiply uses shift-and-add and a divide uses a restoring scheme, and both work on magnitudes with signs fixed up at the end. While a job runs, the requester may go on with unrelated work. It is held only when it next presents a request to this block.

The request side is a valid/ready handshake. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. When `req_ready` is low the requester must keep `req_valid`, `req_func` and the operands steady until the request is taken. `req_ready` is the inverse of `busy`, so every kind of request stalls while a job runs: reads, moves, new arithmetic and unknown codes alike. A read returns its data on `rd_data` in the same cycle as its handshake.

Top module: `hilo_muldiv`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears HI, LO and `busy`. After reset, `req_ready` is high.
- R2: Unsigned multiply (code 011001) leaves bits 63..32 of the 64-bit product in HI and bits 31..0 in LO.
- R3: Signed multiply (code 011000) treats both operands as two's complement and splits the 64-bit signed product the same way as R2.
- R4: Unsigned divide (code 011011) leaves the quotient `req_a / req_b` in LO and the remainder in HI.
- R5: Signed divide (code 011010) truncates the quotient toward zero. The remainder takes the sign of the dividend. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R6: A divide by zero, signed or unsigned, gives LO = 0xFFFFFFFF and HI = the dividend `req_a`.
- R7: Write-HI (010001) copies `req_a` into HI, and write-LO (010011) copies `req_a` into LO. The other register is left unchanged in both cases.
- R8: Read-HI (010000) and read-LO (010010) drive the selected register on `rd_data` in the cycle of the handshake. In every other cycle `rd_data` is zero.
- R9: After an arithmetic request is taken, `busy` stays high for exactly 33 cycles (32 iterations plus one result write). `req_ready` is low whenever `busy` is high.
- R10: HI and LO do not change while a job runs. A request held during a job takes effect only after the job has finished, so a held read returns the new result.
- R11: Any other function code is accepted and changes neither HI nor LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted this cycle when high. Low means stall |
| req_func | input | 6 | Function code |
| req_a | input | 32 | First operand (multiplicand, dividend or move source) |
| req_b | input | 32 | Second operand (multiplier or divisor) |
| rd_data | output | 32 | Read result, valid in the read handshake cycle |
| busy | output | 1 | Multiply or divide in progress |

## Verification
Two functions can meet in one cycle: the final result write of a running job, and a request the requester has been holding against the stall. The bench issues a divide and then, without any gap, presents a read or a write-HI with valid held high. It counts the stalled cycles, which must be exactly 33. It then checks that the read returns the finished quotient, and that a held write-HI replaces the fresh remainder while the quotient in LO survives.

// File: rtl/md_pkg.sv
package md_pkg;
  localparam int FUNC_W = 6;

  localparam logic [FUNC_W-1:0] FN_MUL_S = 6'b011000;
  localparam logic [FUNC_W-1:0] FN_MUL_U = 6'b011001;
  localparam logic [FUNC_W-1:0] FN_DIV_S = 6'b011010;
  localparam logic [FUNC_W-1:0] FN_DIV_U = 6'b011011;
  localparam logic [FUNC_W-1:0] FN_RD_HI = 6'b010000;
  localparam logic [FUNC_W-1:0] FN_WR_HI = 6'b010001;
  localparam logic [FUNC_W-1:0] FN_RD_LO = 6'b010010;
  localparam logic [FUNC_W-1:0] FN_WR_LO = 6'b010011;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;

  typedef struct packed {
    logic is_div;
    logic neg_main;   // negate product or quotient
    logic neg_rem;    // negate remainder
    logic div_zero;
  } md_job_t;
endpackage

// File: rtl/md_operand_prep.sv
module md_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_signed,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_a,
  output logic         neg_b
);
  always_comb begin
    neg_a = is_signed & a[W-1];
    neg_b = is_signed & b[W-1];
    mag_a = neg_a ? (~a + 1'b1) : a;
    mag_b = neg_b ? (~b + 1'b1) : b;
  end
endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] upper_q, lower_q, mcand_q;
  logic [W:0]   partial;

  always_comb begin
    partial = {1'b0, upper_q} + (lower_q[0] ? {1'b0, mcand_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (load) begin
      upper_q <= '0;
      lower_q <= mplier;
      mcand_q <= mcand;
    end else if (step) begin
      upper_q <= partial[W:1];
      lower_q <= {partial[0], lower_q[W-1:1]};
    end
  end

  assign prod = {upper_q, lower_q};
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W:0]   rem_q;
  logic [W-1:0] quo_q, dsr_q;
  logic [W:0]   shifted, trial;

  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    trial   = shifted - {1'b0, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dsr_q <= divisor;
    end else if (step) begin
      if (!trial[W]) begin
        rem_q <= trial;
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted;
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q[W-1:0];
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [W-1:0]      req_a,
  input  logic [W-1:0]      req_b,
  output logic [W-1:0]      rd_data,
  output logic              busy
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(W - 1);

  md_state_e        state_q;
  logic [CNT_W-1:0] iter_q;
  md_job_t          job_q;
  logic [W-1:0]     hi_q, lo_q;

  logic fire, is_mul, is_div, is_signed, start;
  logic [W-1:0] mag_a, mag_b;
  logic neg_a, neg_b;
  logic [2*W-1:0] prod, prod_fix;
  logic [W-1:0] quo, rem, quo_fix, rem_fix;

  always_comb begin
    fire      = req_valid & req_ready;
    is_mul    = (req_func == FN_MUL_S) | (req_func == FN_MUL_U);
    is_div    = (req_func == FN_DIV_S) | (req_func == FN_DIV_U);
    is_signed = (req_func == FN_MUL_S) | (req_func == FN_DIV_S);
    start     = fire & (is_mul | is_div);
  end

  md_operand_prep #(.W(W)) u_prep (
    .a(req_a), .b(req_b), .is_signed(is_signed),
    .mag_a(mag_a), .mag_b(mag_b), .neg_a(neg_a), .neg_b(neg_b)
  );

  md_mul_core #(.W(W)) u_mul (
    .clk(clk), .load(start), .step(state_q == ST_RUN),
    .mcand(mag_a), .mplier(mag_b), .prod(prod)
  );

  md_div_core #(.W(W)) u_div (
    .clk(clk), .load(start), .step(state_q == ST_RUN),
    .dividend(mag_a), .divisor(mag_b), .quo(quo), .rem(rem)
  );

  // Sign repair of magnitude results
  always_comb begin
    prod_fix = job_q.neg_main ? (~prod + 1'b1) : prod;
    quo_fix  = job_q.div_zero ? '1 : (job_q.neg_main ? (~quo + 1'b1) : quo);
    rem_fix  = job_q.neg_rem ? (~rem + 1'b1) : rem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      job_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q        <= ST_RUN;
            iter_q         <= '0;
            job_q.is_div   <= is_div;
            job_q.neg_main <= neg_a ^ neg_b;
            job_q.neg_rem  <= neg_a;
            job_q.div_zero <= is_div & (req_b == '0);
          end else if (fire && req_func == FN_WR_HI) begin
            hi_q <= req_a;
          end else if (fire && req_func == FN_WR_LO) begin
            lo_q <= req_a;
          end
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (iter_q == LAST_ITER) state_q <= ST_FIN;
        end
        ST_FIN: begin
          state_q <= ST_IDLE;
          if (job_q.is_div) begin
            lo_q <= quo_fix;
            hi_q <= rem_fix;
          end else begin
            lo_q <= prod_fix[W-1:0];
            hi_q <= prod_fix[2*W-1:W];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state_q != ST_IDLE);
    req_ready = ~busy;
    rd_data   = '0;
    if (fire && req_func == FN_RD_HI) rd_data = hi_q;
    else if (fire && req_func == FN_RD_LO) rd_data = lo_q;
  end
endmodule

// File: rtl/md_checker.sv
module md_checker
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [FUNC_W-1:0] req_func,
  input logic [W-1:0]      req_a,
  input logic [W-1:0]      rd_data,
  input logic              busy,
  input logic [W-1:0]      hi_q,
  input logic [W-1:0]      lo_q
);
  logic [7:0] run_len;
  logic take, known;

  always_comb begin
    take  = req_valid & req_ready;
    known = (req_func inside {FN_MUL_S, FN_MUL_U, FN_DIV_S, FN_DIV_U,
                              FN_RD_HI, FN_WR_HI, FN_RD_LO, FN_WR_LO});
  end

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (hi_q == '0 && lo_q == '0 && !busy));

  assert_stall_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  assert_run_length_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == 8'(W + 1));

  assert_hilo_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

  assert_write_hi_R7: assert property (@(posedge clk) disable iff (rst)
    (take && req_func == FN_WR_HI) |=> (hi_q == $past(req_a) && $stable(lo_q)));

  assert_write_lo_R7: assert property (@(posedge clk) disable iff (rst)
    (take && req_func == FN_WR_LO) |=> (lo_q == $past(req_a) && $stable(hi_q)));

  assert_read_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(take && (req_func == FN_RD_HI || req_func == FN_RD_LO)) |-> rd_data == '0);

  assert_other_code_R11: assert property (@(posedge clk) disable iff (rst)
    (take && !known) |=> ($stable(hi_q) && $stable(lo_q) && !busy));
endmodule

bind hilo_muldiv md_checker #(.W(W)) u_md_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_func(req_func), .req_a(req_a), .rd_data(rd_data), .busy(busy),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/hilo_muldiv_bench.sv
module hilo_muldiv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_func = '0;
  logic [31:0] req_a = '0, req_b = '0;
  logic [31:0] rd_data;
  logic        busy;

  int n_checks = 0;
  int n_fail = 0;
  bit timed_out = 1'b0;

  hilo_muldiv u_hilo_muldiv (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_func(req_func), .req_a(req_a), .req_b(req_b),
    .rd_data(rd_data), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present a request, hold it while stalled, return read data and stall count
  task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] rd, output int waited);
    @(negedge clk);
    req_valid = 1'b1; req_func = f; req_a = a; req_b = b;
    waited = 0;
    #1;
    while (!req_ready && waited < WAIT_LIMIT) begin
      @(negedge clk); #1;
      waited++;
    end
    if (waited >= WAIT_LIMIT) timed_out = 1'b1;
    rd = rd_data;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] hi, output logic [31:0] lo);
    logic [31:0] d; int w;
    issue(f, a, b, d, w);
    issue(6'b010000, 0, 0, hi, w);
    issue(6'b010010, 0, 0, lo, w);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(busy == 1'b0 && req_ready == 1'b1, "R1 idle after reset", {30'b0, busy, req_ready}, 32'h1);
    check(rd_data == 32'h0, "R8 rd_data quiet", rd_data, 32'h0);
    begin
      logic [31:0] hi, lo; int w;
      issue(6'b010000, 0, 0, hi, w);
      issue(6'b010010, 0, 0, lo, w);
      check(hi == 32'h0, "R1 HI cleared", hi, 32'h0);
      check(lo == 32'h0, "R1 LO cleared", lo, 32'h0);
    end
  endtask

  task automatic t_mul(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] hi, lo; logic [63:0] e;
    if (sgn) e = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
    else     e = {32'b0, a} * {32'b0, b};
    run_op(sgn ? 6'b011000 : 6'b011001, a, b, hi, lo);
    check(hi == e[63:32], sgn ? "R3 signed mul HI" : "R2 unsigned mul HI", hi, e[63:32]);
    check(lo == e[31:0],  sgn ? "R3 signed mul LO" : "R2 unsigned mul LO", lo, e[31:0]);
  endtask

  task automatic t_div(input bit sgn, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] hi, lo, eq, er; longint sa, sb;
    if (b == 32'h0) begin
      eq = 32'hFFFF_FFFF; er = a;
    end else if (sgn) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      eq = 32'(sa / sb); er = 32'(sa % sb);
    end else begin
      eq = a / b; er = a % b;
    end
    run_op(sgn ? 6'b011010 : 6'b011011, a, b, hi, lo);
    if (b == 32'h0) begin
      check(lo == eq, "R6 div by zero LO", lo, eq);
      check(hi == er, "R6 div by zero HI", hi, er);
    end else begin
      check(lo == eq, sgn ? "R5 signed div LO" : "R4 unsigned div LO", lo, eq);
      check(hi == er, sgn ? "R5 signed div HI" : "R4 unsigned div HI", hi, er);
    end
  endtask

  task automatic t_moves;
    logic [31:0] d, hi, lo; int w;
    issue(6'b010001, 32'hA5A5_0001, 0, d, w);
    issue(6'b010011, 32'h5A5A_0002, 0, d, w);
    issue(6'b010001, 32'h1234_5678, 0, d, w);
    issue(6'b010000, 0, 0, hi, w);
    issue(6'b010010, 0, 0, lo, w);
    check(hi == 32'h1234_5678, "R7 write HI", hi, 32'h1234_5678);
    check(lo == 32'h5A5A_0002, "R7 LO kept on write HI", lo, 32'h5A5A_0002);
    check(w == 0, "R8 read has no stall when idle", w, 0);
  endtask

  task automatic t_busy_len;
    logic [31:0] d; int w, n;
    issue(6'b011001, 32'd7, 32'd9, d, w);
    n = 0;
    @(negedge clk);
    while (busy && n < WAIT_LIMIT) begin
      check(req_ready == 1'b0, "R9 ready low while busy", {31'b0, req_ready}, 0);
      n++;
      @(negedge clk);
    end
    check(n == 33, "R9 busy length", n, 33);
  endtask

  task automatic t_held_read;
    logic [31:0] d, lo; int w;
    issue(6'b011011, 32'd1000, 32'd7, d, w);
    // Peek while the read is held against the stall
    @(negedge clk);
    req_valid = 1'b1; req_func = 6'b010010; #1;
    check(rd_data == 32'h0, "R8 rd_data zero while stalled", rd_data, 0);
    req_valid = 1'b0;
    issue(6'b010010, 0, 0, lo, w);
    check(lo == 32'd142, "R10 held read gets new quotient", lo, 32'd142);
    check(w == 32, "R10 held read stall count", w, 32);
  endtask

  task automatic t_held_write;
    logic [31:0] d, hi, lo; int w;
    issue(6'b011011, 32'd100, 32'd9, d, w);
    issue(6'b010001, 32'hDEAD_BEEF, 0, d, w);
    check(w == 33, "R10 held write stall count", w, 33);
    issue(6'b010000, 0, 0, hi, w);
    issue(6'b010010, 0, 0, lo, w);
    check(hi == 32'hDEAD_BEEF, "R10 held write lands after result", hi, 32'hDEAD_BEEF);
    check(lo == 32'd11, "R10 quotient survives held write", lo, 32'd11);
  endtask

  task automatic t_other_code;
    logic [31:0] d, hi, lo; int w;
    issue(6'b010001, 32'h0000_1111, 0, d, w);
    issue(6'b010011, 32'h0000_2222, 0, d, w);
    issue(6'b100000, 32'hFFFF_FFFF, 32'h3, d, w);
    check(busy == 1'b0, "R11 other code starts nothing", {31'b0, busy}, 0);
    issue(6'b001101, 32'hFFFF_FFFF, 32'h3, d, w);
    issue(6'b010000, 0, 0, hi, w);
    issue(6'b010010, 0, 0, lo, w);
    check(hi == 32'h1111, "R11 HI untouched", hi, 32'h1111);
    check(lo == 32'h2222, "R11 LO untouched", lo, 32'h2222);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_mul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mul(1'b0, 32'h0001_0000, 32'h0003_0005);
    t_mul(1'b1, 32'hFFFF_FFFD, 32'h0000_0007);
    t_mul(1'b1, 32'h8000_0000, 32'h8000_0000);
    t_div(1'b0, 32'hFFFF_FFFF, 32'h0000_0010);
    t_div(1'b0, 32'd5, 32'd9);
    t_div(1'b1, 32'hFFFF_FFF9, 32'd2);
    t_div(1'b1, 32'd7, 32'hFFFF_FFFE);
    t_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
    t_div(1'b0, 32'h1234_5678, 32'h0);
    t_div(1'b1, 32'hFFFF_FF00, 32'h0);
    t_moves();
    t_busy_len();
    t_held_read();
    t_held_write();
    t_other_code();
    if (timed_out) check(1'b0, "R9 stall never released", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule